// File: doc/BRIEF.md
# FIFO DMA Request Controller

This block generates the DMA request line for a parallel-port FIFO whose data port is served by a system DMA channel. The request is raised when DMA is enabled, the service bit is clear, the port is in one of the FIFO-based modes, and the FIFO can accept data (host-to-peripheral) or supply data (peripheral-to-host). In the FIFO test mode the FIFO flags are ignored.

While the DMA acknowledge is low, each completed host write strobe produces a one-cycle push pulse and each completed read strobe produces a one-cycle pop pulse. A completed strobe is the rising edge of the active-low strobe.

Three termination causes are handled, each with its own restart rule:

- A full or empty FIFO drops the request, and the request resumes on its own once that flag clears.
- A burst of more than 32 consecutive strobe cycles drops the request until the acknowledge goes high again.
- A terminal count drops the request and emits a pulse that sets the service bit. The request then stays off until software clears the service bit.

Top module: `dmareq_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `drq_o`, `fifo_push_o`, `fifo_pop_o` and `svc_set_o` are 0.
- R2: `drq_o` is a registered output and is 1 one cycle after the following all hold:
  - `dma_en_i`=1 and `svc_i`=0;
  - the mode is FIFO (3'b010) or ECP (3'b011);
  - either `dir_in_i`=0 (host to peripheral) with `fifo_full_i`=0, or `dir_in_i`=1 (peripheral to host) with `fifo_empty_i`=0;
  - no burst or terminal-count stop is pending.
- R3: In test mode (3'b110), `drq_o` is requested regardless of `fifo_full_i`, `fifo_empty_i` and `dir_in_i`.
- R4: In any mode other than 3'b010, 3'b011 and 3'b110, `drq_o` stays 0 and no push or pop pulse is produced.
- R5: With `dir_in_i`=0, `fifo_full_i`=1 drops `drq_o`. With `dir_in_i`=1, `fifo_empty_i`=1 drops `drq_o`. In both cases the request returns without any other action once the flag clears.
- R6: `svc_i`=1 or `dma_en_i`=0 holds `drq_o` at 0.
- R7: A rising edge on `iow_n_i` while `dack_n_i`=0 in a DMA mode gives a one-cycle `fifo_push_o` pulse in the following cycle. A rising edge on `ior_n_i` under the same conditions gives a one-cycle `fifo_pop_o` pulse.
- R8: Completed strobe cycles are counted while `dack_n_i`=0. Once more than 32 have been counted, `drq_o` drops. The count saturates, so further strobes do not bring the request back.
- R9: `dack_n_i`=1 clears the strobe count, and the request resumes if its other conditions hold.
- R10: `tc_i`=1 while `dack_n_i`=0 in a DMA mode with `dma_en_i`=1 has two effects:
  - it gives a one-cycle `svc_set_o` pulse;
  - it holds `drq_o` at 0 until `svc_i` has gone from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en_i | input | 1 | DMA enable bit |
| svc_i | input | 1 | Service bit (1 blocks requests) |
| mode_i | input | 3 | Port mode: 010 FIFO, 011 ECP, 110 test |
| dir_in_i | input | 1 | 0 host to peripheral, 1 peripheral to host |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| ior_n_i | input | 1 | Host read strobe, active low |
| iow_n_i | input | 1 | Host write strobe, active low |
| tc_i | input | 1 | DMA terminal count |
| drq_o | output | 1 | DMA request |
| fifo_push_o | output | 1 | One-cycle FIFO write pulse |
| fifo_pop_o | output | 1 | One-cycle FIFO read pulse |
| svc_set_o | output | 1 | One-cycle pulse that sets the service bit |

## Verification
The request is first exercised in both directions with each FIFO flag toggled, which distinguishes a flag-gated request from one that ignores direction. Test mode and illegal modes are then driven with both flags asserted, which separates the flag bypass from mode gating.

A run of 35 write strobes under a held acknowledge shows three things:
- the stop falls exactly after the 33rd strobe;
- the stop survives extra strobes, so the count saturates rather than wrapping;
- the acknowledge release is the only thing that re-arms the burst.

A terminal count followed by a service-bit set and clear shows that only software re-arms after a terminal count. A per-clock reference model compares every output on every cycle.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  localparam logic [2:0] MODE_FIFO = 3'b010;
  localparam logic [2:0] MODE_ECP  = 3'b011;
  localparam logic [2:0] MODE_TEST = 3'b110;

  function automatic logic is_dma_mode(input logic [2:0] m);
    return (m == MODE_FIFO) || (m == MODE_ECP) || (m == MODE_TEST);
  endfunction
endpackage

// File: rtl/dmareq_strobe.sv
module dmareq_strobe (
  input  logic clk,
  input  logic rst,
  input  logic dma_mode_i,
  input  logic dack_n_i,
  input  logic ior_n_i,
  input  logic iow_n_i,
  output logic cycle_done_o,
  output logic push_o,
  output logic pop_o
);
  logic ior_q, iow_q;
  logic wr_rise, rd_rise, active;

  assign active       = dma_mode_i & ~dack_n_i;
  assign wr_rise      = iow_n_i & ~iow_q;
  assign rd_rise      = ior_n_i & ~ior_q;
  assign cycle_done_o = active & (wr_rise | rd_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      ior_q  <= 1'b1;
      iow_q  <= 1'b1;
      push_o <= 1'b0;
      pop_o  <= 1'b0;
    end else begin
      ior_q  <= ior_n_i;
      iow_q  <= iow_n_i;
      push_o <= active & wr_rise;
      pop_o  <= active & rd_rise;
    end
  end

  p_push_dack_r7: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(!dack_n_i));
  p_pop_dack_r7: assert property (@(posedge clk) disable iff (rst)
    pop_o |-> $past(!dack_n_i));
endmodule

// File: rtl/dmareq_burst.sv
module dmareq_burst #(
  parameter int BURST_MAX = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic cycle_done_i,
  output logic stop_o
);
  localparam int CW = $clog2(BURST_MAX + 2);
  localparam logic [CW-1:0] LIMIT = CW'(BURST_MAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      cnt <= '0;
    else if (cycle_done_i && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign stop_o = (cnt == LIMIT);

  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_o && !clear_i) |=> stop_o);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !stop_o);
endmodule

// File: rtl/dmareq_gate.sv
module dmareq_gate
  import dmareq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dma_en_i,
  input  logic       svc_i,
  input  logic [2:0] mode_i,
  input  logic       dir_in_i,
  input  logic       fifo_full_i,
  input  logic       fifo_empty_i,
  input  logic       dack_n_i,
  input  logic       tc_i,
  input  logic       burst_stop_i,
  output logic       drq_o,
  output logic       svc_set_o
);
  logic svc_q, tc_hold, data_ok, want, tc_hit, dma_mode;

  assign dma_mode = is_dma_mode(mode_i);
  assign tc_hit   = tc_i & ~dack_n_i & dma_en_i & dma_mode;
  assign data_ok  = (mode_i == MODE_TEST) ||
                    (!dir_in_i && !fifo_full_i) ||
                    ( dir_in_i && !fifo_empty_i);
  assign want     = dma_en_i & ~svc_i & dma_mode & data_ok &
                    ~tc_hold & ~burst_stop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q     <= 1'b0;
      tc_hold   <= 1'b0;
      drq_o     <= 1'b0;
      svc_set_o <= 1'b0;
    end else begin
      svc_q     <= svc_i;
      drq_o     <= want;
      svc_set_o <= tc_hit;
      if (tc_hit)
        tc_hold <= 1'b1;
      else if (svc_q && !svc_i)
        tc_hold <= 1'b0;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!drq_o && !svc_set_o));
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (rst)
    drq_o |-> $past(is_dma_mode(mode_i)));
  p_full_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_TEST && !dir_in_i && fifo_full_i) |=> !drq_o);
  p_svc_block_r6: assert property (@(posedge clk) disable iff (rst)
    (svc_i || !dma_en_i) |=> !drq_o);
endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
  import dmareq_pkg::*;
#(
  parameter int BURST_MAX = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dma_en_i,
  input  logic       svc_i,
  input  logic [2:0] mode_i,
  input  logic       dir_in_i,
  input  logic       fifo_full_i,
  input  logic       fifo_empty_i,
  input  logic       dack_n_i,
  input  logic       ior_n_i,
  input  logic       iow_n_i,
  input  logic       tc_i,
  output logic       drq_o,
  output logic       fifo_push_o,
  output logic       fifo_pop_o,
  output logic       svc_set_o
);
  logic cycle_done, burst_stop;

  dmareq_strobe u_strobe (
    .clk          (clk),
    .rst          (rst),
    .dma_mode_i   (is_dma_mode(mode_i)),
    .dack_n_i     (dack_n_i),
    .ior_n_i      (ior_n_i),
    .iow_n_i      (iow_n_i),
    .cycle_done_o (cycle_done),
    .push_o       (fifo_push_o),
    .pop_o        (fifo_pop_o)
  );

  dmareq_burst #(.BURST_MAX(BURST_MAX)) u_burst (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (dack_n_i),
    .cycle_done_i (cycle_done),
    .stop_o       (burst_stop)
  );

  dmareq_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .dma_en_i     (dma_en_i),
    .svc_i        (svc_i),
    .mode_i       (mode_i),
    .dir_in_i     (dir_in_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .dack_n_i     (dack_n_i),
    .tc_i         (tc_i),
    .burst_stop_i (burst_stop),
    .drq_o        (drq_o),
    .svc_set_o    (svc_set_o)
  );

  p_burst_cap_r8: assert property (@(posedge clk) disable iff (rst)
    burst_stop |=> !drq_o);
  p_tc_block_r10: assert property (@(posedge clk) disable iff (rst)
    svc_set_o |=> !drq_o);
endmodule

// File: tb/dmareq_ctrl_test.sv
module dmareq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int BMAX = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_en = 0, svc = 0, dir_in = 0, full = 0, empty = 0;
  logic dack_n = 1, ior_n = 1, iow_n = 1, tc = 0;
  logic [2:0] mode = 3'b000;
  logic drq, push, pop, sset;

  int checks = 0, failures = 0, cycles = 0;

  // reference model state
  int m_cnt = 0;
  bit m_iowq = 1, m_iorq = 1, m_svcq = 0, m_hold = 0;
  bit m_drq = 0, m_push = 0, m_pop = 0, m_sset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareq_ctrl #(.BURST_MAX(BMAX)) uut (
    .clk(clk), .rst(rst), .dma_en_i(dma_en), .svc_i(svc), .mode_i(mode),
    .dir_in_i(dir_in), .fifo_full_i(full), .fifo_empty_i(empty),
    .dack_n_i(dack_n), .ior_n_i(ior_n), .iow_n_i(iow_n), .tc_i(tc),
    .drq_o(drq), .fifo_push_o(push), .fifo_pop_o(pop), .svc_set_o(sset)
  );

  function automatic bit mdma(input logic [2:0] m);
    return m == 3'b010 || m == 3'b011 || m == 3'b110;
  endfunction

  always @(posedge clk) begin
    bit act, wr, rd, hit, ok, nd;
    cycles++;
    if (rst) begin
      m_cnt = 0; m_iowq = 1; m_iorq = 1; m_svcq = 0; m_hold = 0;
      m_drq = 0; m_push = 0; m_pop = 0; m_sset = 0;
    end else begin
      act = mdma(mode) && !dack_n;
      wr  = iow_n && !m_iowq;
      rd  = ior_n && !m_iorq;
      hit = tc && !dack_n && dma_en && mdma(mode);
      ok  = (mode == 3'b110) || (!dir_in && !full) || (dir_in && !empty);
      nd  = dma_en && !svc && mdma(mode) && ok && !m_hold && !(m_cnt > BMAX);
      m_drq = nd; m_push = act && wr; m_pop = act && rd; m_sset = hit;
      if (dack_n) m_cnt = 0;
      else if (act && (wr || rd) && m_cnt <= BMAX) m_cnt++;
      if (hit) m_hold = 1;
      else if (m_svcq && !svc) m_hold = 0;
      m_iowq = iow_n; m_iorq = ior_n; m_svcq = svc;
    end
  end

  always @(negedge clk) begin
    if (cycles > 1) begin
      checks++;
      if (drq !== m_drq || push !== m_push || pop !== m_pop || sset !== m_sset) begin
        failures++;
        $display("FAIL R2/R7/R10 model: drq=%0b push=%0b pop=%0b sset=%0b exp %0b %0b %0b %0b",
                 drq, push, pop, sset, m_drq, m_push, m_pop, m_sset);
      end
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_pulse();
    @(negedge clk) iow_n = 0;
    @(negedge clk) iow_n = 1;
  endtask

  initial begin
    wait_n(3);
    chk("R1 drq in reset", drq, 1'b0);
    chk("R1 svc_set in reset", sset, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 push after reset", push, 1'b0);

    // R2 output direction
    mode = 3'b010; dma_en = 1; dir_in = 0; full = 0; empty = 1;
    wait_n(2); chk("R2 request out dir", drq, 1'b1);
    full = 1; wait_n(2); chk("R5 drop on full", drq, 1'b0);
    full = 0; wait_n(2); chk("R5 resume after full", drq, 1'b1);
    // input direction
    mode = 3'b011; dir_in = 1; empty = 1; full = 0;
    wait_n(2); chk("R5 drop on empty", drq, 1'b0);
    empty = 0; wait_n(2); chk("R2 request in dir", drq, 1'b1);
    // test mode bypass
    mode = 3'b110; full = 1; empty = 1;
    wait_n(2); chk("R3 test mode in dir", drq, 1'b1);
    dir_in = 0; wait_n(2); chk("R3 test mode out dir", drq, 1'b1);
    // illegal modes
    full = 0; empty = 0;
    mode = 3'b001; wait_n(2); chk("R4 mode 001", drq, 1'b0);
    mode = 3'b111; dack_n = 0; wr_pulse(); @(negedge clk);
    chk("R4 no push in mode 111", push, 1'b0);
    dack_n = 1; wait_n(2); chk("R4 mode 111", drq, 1'b0);
    // service bit and enable
    mode = 3'b010; svc = 1; wait_n(2); chk("R6 svc blocks", drq, 1'b0);
    svc = 0; dma_en = 0; wait_n(2); chk("R6 disable blocks", drq, 1'b0);
    dma_en = 1; wait_n(2); chk("R6 request returns", drq, 1'b1);
    // R7 push/pop pulses
    dack_n = 0;
    @(negedge clk) iow_n = 0;
    @(negedge clk) iow_n = 1;
    @(negedge clk) chk("R7 push pulse", push, 1'b1);
    @(negedge clk) chk("R7 push one cycle", push, 1'b0);
    @(negedge clk) ior_n = 0;
    @(negedge clk) ior_n = 1;
    @(negedge clk) chk("R7 pop pulse", pop, 1'b1);
    dack_n = 1; wait_n(2);
    // R8 burst cap
    dack_n = 0;
    for (int i = 0; i < BMAX; i++) wr_pulse();
    wait_n(2); chk("R8 still requesting after 32", drq, 1'b1);
    wr_pulse(); wait_n(2); chk("R8 stop after 33", drq, 1'b0);
    wr_pulse(); wr_pulse(); wait_n(2); chk("R8 saturates", drq, 1'b0);
    dack_n = 1; wait_n(2); chk("R9 ack high resumes", drq, 1'b1);
    // R10 terminal count
    dack_n = 0;
    @(negedge clk) tc = 1;
    @(negedge clk) tc = 0;
    chk("R10 svc_set pulse", sset, 1'b1);
    dack_n = 1; wait_n(3); chk("R10 held after tc", drq, 1'b0);
    svc = 1; wait_n(2); chk("R10 held with svc", drq, 1'b0);
    svc = 0; wait_n(3); chk("R10 resumes after svc clear", drq, 1'b1);

    wait_n(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule